// File: doc/BRIEF.md
# Idle Monitor and Access Trap

This block helps power-management firmware decide when the devices of a small I/O subsystem may be powered down, and catch the first access to a device once it is down. Each device has a bit that records that the device was accessed. Software clears any of these bits by writing a one to it. A periodic timer, enabled by a control bit, raises a management interrupt at a fixed interval. The handler can then sample the activity bits and count idle intervals.

Each device also has a trap-arm bit. While that bit is set, an access to the device is held back: the block drops the device's forward strobe, records the device in a trap-hit register and raises the interrupt. The handler powers the device back up and disarms the trap. After that, accesses reach the device again. The interrupt output is high while a timer expiry or any trap hit is pending.

Accesses arrive as one strobe per device on `acc_valid`. Each strobe leaves on `acc_fwd` unless that device is trapped. Registers sit behind a single-cycle write port with a combinational read.

Top module: `idlemon_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. With no trap armed, `acc_fwd` equals `acc_valid` in the same cycle.
- R2: An access that is forwarded sets the activity bit of its device on the next clock edge. The device bits are: bit 0 serial port, bit 1 parallel port, bit 2 floppy controller, bit 3 keyboard controller, bit 4 audio.
- R3: Writing to the activity register (address 1) clears exactly the bits written as one. Bits written as zero keep their value. A set and a clear of the same bit on the same edge leave the bit set.
- R4: While a device's trap-arm bit (address 2) is set, its `acc_fwd` bit stays low during an access. Its bit in the trap-hit register (address 3) is set on the next edge.
- R5: A trapped access does not set that device's activity bit.
- R6: Once software clears a trap-arm bit, accesses to that device are forwarded again. `acc_fwd` is never high without the matching `acc_valid`.
- R7: While the timer enable (address 0, bit 0) is set, the expiry bit (address 4, bit 0) is set TICK_CYCLES edges after the edge that registered the enable, and again every TICK_CYCLES edges after that. While the enable is clear, the expiry bit is never set.
- R8: The timer count returns to zero whenever the enable is clear. A re-enable therefore waits a full interval before the next expiry.
- R9: The trap-hit and expiry registers are write-one-to-clear. A new set on the same edge as a clear wins.
- R10: `irq` is high exactly when the expiry bit or any trap-hit bit is set.
- R11: Writes to address 0 keep only bit 0, and writes to address 2 keep only the N_DEV low bits. Every register reads back through `reg_rdata`, and unused upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from reg_addr |
| acc_valid | input | N_DEV | Per-device access strobe |
| acc_fwd | output | N_DEV | Per-device strobe passed on to the device |
| irq | output | 1 | Management interrupt request |

## Verification
The main sweep crosses all 32 access patterns with all 32 trap-arm patterns. This separates forwarded from trapped strobes bit by bit, and shows that a trapped access lands only in the trap-hit register. A second sweep writes all 32 clear masks over a full activity register, which tells write-one-to-clear apart from plain writes and from clear-all. Timer runs count edges exactly across two intervals, with a clear that collides with an expiry. A disable and re-enable partway through an interval tells a restarted count from one that only pauses.

// File: rtl/idlemon_pkg.sv
package idlemon_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_ACT  = 3'd1,
        A_ARM  = 3'd2,
        A_HIT  = 3'd3,
        A_TICK = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/idlemon_w1c.sv
module idlemon_w1c #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t s_d, s_q;

    // set has priority over a same-cycle clear
    always_comb begin
        s_d      = s_q;
        s_d.bits = (s_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o = s_q.bits;
endmodule

// File: rtl/idlemon_timer.sv
module idlemon_timer #(
    parameter int unsigned TICK_CYCLES = 6000,
    localparam int unsigned CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        expire_o = 1'b0;
        if (!en_i) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == LAST) begin
            s_d.cnt  = '0;
            expire_o = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/idlemon_top.sv
module idlemon_top
    import idlemon_pkg::*;
#(
    parameter int unsigned N_DEV       = 5,
    parameter int unsigned DW          = 8,
    parameter int unsigned TICK_CYCLES = 6000,
    localparam int unsigned CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [N_DEV-1:0]    acc_valid,
    output logic [N_DEV-1:0]    acc_fwd,
    output logic                irq
);
    typedef struct packed {
        logic             en;
        logic [N_DEV-1:0] arm;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [N_DEV-1:0] act_q, hit_q;
    logic [N_DEV-1:0] act_set, act_clr, hit_set, hit_clr;
    logic             tick_q, tick_clr, expire;
    logic [CNT_W-1:0] cnt_q;

    // control registers
    always_comb begin
        c_d = c_q;
        if (reg_wr && reg_addr == A_CTRL) c_d.en  = reg_wdata[0];
        if (reg_wr && reg_addr == A_ARM)  c_d.arm = reg_wdata[N_DEV-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // access path: trapped strobes are swallowed
    always_comb begin
        acc_fwd = acc_valid & ~c_q.arm;
        act_set = acc_fwd;
        hit_set = acc_valid & c_q.arm;
        act_clr = (reg_wr && reg_addr == A_ACT)  ? reg_wdata[N_DEV-1:0] : '0;
        hit_clr = (reg_wr && reg_addr == A_HIT)  ? reg_wdata[N_DEV-1:0] : '0;
        tick_clr = reg_wr && reg_addr == A_TICK && reg_wdata[0];
    end

    idlemon_w1c #(.W(N_DEV)) u_act (
        .clk(clk), .rst_n(rst_n), .set_i(act_set), .clr_i(act_clr), .q_o(act_q)
    );

    idlemon_w1c #(.W(N_DEV)) u_hit (
        .clk(clk), .rst_n(rst_n), .set_i(hit_set), .clr_i(hit_clr), .q_o(hit_q)
    );

    idlemon_w1c #(.W(1)) u_tick (
        .clk(clk), .rst_n(rst_n), .set_i(expire), .clr_i(tick_clr), .q_o(tick_q)
    );

    idlemon_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .en_i(c_q.en), .expire_o(expire), .cnt_o(cnt_q)
    );

    assign irq = tick_q | (|hit_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata = DW'(c_q.en);
            A_ACT:   reg_rdata = DW'(act_q);
            A_ARM:   reg_rdata = DW'(c_q.arm);
            A_HIT:   reg_rdata = DW'(hit_q);
            A_TICK:  reg_rdata = DW'(tick_q);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/idlemon_chk.sv
module idlemon_chk
    import idlemon_pkg::*;
#(
    parameter int unsigned N_DEV       = 5,
    parameter int unsigned DW          = 8,
    parameter int unsigned TICK_CYCLES = 6000,
    parameter int unsigned CNT_W       = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [N_DEV-1:0]  acc_valid,
    input logic [N_DEV-1:0]  acc_fwd,
    input logic              irq,
    input logic              en_q,
    input logic [N_DEV-1:0]  arm_q,
    input logic [N_DEV-1:0]  act_q,
    input logic [N_DEV-1:0]  hit_q,
    input logic [CNT_W-1:0]  cnt_q
);
    logic [N_DEV-1:0] wr_act_mask, trapped, passed;

    always_comb begin
        wr_act_mask = (reg_wr && reg_addr == A_ACT) ? reg_wdata[N_DEV-1:0] : '0;
        trapped     = acc_valid & arm_q;
        passed      = acc_valid & ~arm_q;
    end

    AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (passed != '0) |=> ((act_q & $past(passed)) == $past(passed))); // R2

    AST_ACT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != '0) |=> ((act_q & $past(act_q & ~wr_act_mask)) == $past(act_q & ~wr_act_mask))); // R3

    AST_TRAP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (trapped != '0) |=> ((hit_q & $past(trapped)) == $past(trapped))); // R4

    AST_TRAP_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (trapped != '0) |=> ((act_q & ~$past(act_q) & $past(trapped)) == '0)); // R5

    AST_FWD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fwd & ~acc_valid) == '0); // R6

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(TICK_CYCLES)); // R7

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (cnt_q == '0)); // R8

    AST_IRQ_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (trapped != '0) |=> irq); // R10
endmodule

bind idlemon_top idlemon_chk #(
    .N_DEV(N_DEV), .DW(DW), .TICK_CYCLES(TICK_CYCLES), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_fwd(acc_fwd), .irq(irq),
    .en_q(c_q.en), .arm_q(c_q.arm), .act_q(act_q), .hit_q(hit_q), .cnt_q(cnt_q)
);

// File: tb/test_idlemon_top.sv
module test_idlemon_top;
    localparam int N    = 5;
    localparam int DW   = 8;
    localparam int TICK = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [N-1:0]  acc_valid = '0;
    logic [N-1:0]  acc_fwd;
    logic          irq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    idlemon_top #(.N_DEV(N), .DW(DW), .TICK_CYCLES(TICK)) i_idlemon_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_fwd(acc_fwd), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic pulse(input logic [N-1:0] a);
        acc_valid = a;
        @(negedge clk);
        acc_valid = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reg reset", v, 0);
        end
        check("R1 irq reset", int'(irq), 0);
        acc_valid = 5'h15; #1;
        check("R1 fwd passthrough", int'(acc_fwd), 'h15);
        acc_valid = '0;
        @(negedge clk);
        wr(3'd1, 8'hFF);

        // R11 register map and widths
        wr(3'd2, 8'hFF); rd(3'd2, v);
        check("R11 arm width", v, 'h1F);
        wr(3'd0, 8'hFE); rd(3'd0, v);
        check("R11 ctrl bit0 only", v, 0);
        wr(3'd2, 8'h00);

        // R2 R4 R5 R10 sweep over access x arm patterns
        for (int t = 0; t < 32; t++) begin
            for (int a = 0; a < 32; a++) begin
                wr(3'd2, 8'(t));
                wr(3'd1, 8'hFF);
                wr(3'd3, 8'hFF);
                acc_valid = 5'(a); #1;
                check("R4 fwd blocked", int'(acc_fwd), a & ~t & 31);
                @(negedge clk);
                acc_valid = '0;
                rd(3'd1, v); check("R2 R5 activity", v, a & ~t & 31);
                rd(3'd3, v); check("R4 trap hit", v, a & t);
                check("R10 irq", int'(irq), int'((a & t) != 0));
            end
        end
        wr(3'd3, 8'hFF);
        check("R10 irq cleared", int'(irq), 0);

        // R6 disarm restores forwarding
        wr(3'd2, 8'h1F); wr(3'd1, 8'hFF);
        acc_valid = 5'h1F; #1;
        check("R6 armed fwd", int'(acc_fwd), 0);
        acc_valid = '0;
        wr(3'd2, 8'h00);
        acc_valid = 5'h1F; #1;
        check("R6 disarmed fwd", int'(acc_fwd), 'h1F);
        @(negedge clk); acc_valid = '0;
        rd(3'd1, v); check("R6 activity after disarm", v, 'h1F);
        wr(3'd3, 8'hFF);

        // R3 clear-mask sweep
        for (int m = 0; m < 32; m++) begin
            pulse(5'h1F);
            wr(3'd1, 8'(m));
            rd(3'd1, v);
            check("R3 w1c mask", v, 31 & ~m);
        end
        wr(3'd1, 8'hFF);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h01; acc_valid = 5'h01;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; acc_valid = '0;
        rd(3'd1, v); check("R3 set beats clear", v, 1);
        wr(3'd1, 8'hFF);

        // R9 trap-hit set wins and clear
        wr(3'd2, 8'h02);
        pulse(5'h02);
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h02; acc_valid = 5'h02;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; acc_valid = '0;
        rd(3'd3, v); check("R9 hit set beats clear", v, 2);
        wr(3'd3, 8'h02);
        rd(3'd3, v); check("R9 hit cleared", v, 0);
        check("R10 irq low", int'(irq), 0);
        wr(3'd2, 8'h00);

        // R7 R9 R10 timer: two intervals, clear, and colliding clear
        wr(3'd0, 8'h01);
        for (int k = 1; k <= 2 * TICK; k++) begin
            int e;
            @(negedge clk);
            if (k < TICK) e = 0;
            else if (k <= TICK + 2) e = 1;
            else if (k < 2 * TICK) e = 0;
            else e = 1;
            check("R7 R9 R10 tick irq", int'(irq), e);
            if (k == TICK + 2 || k == 2 * TICK - 1) begin
                reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h01;
            end else begin
                reg_wr = 1'b0; reg_wdata = '0;
            end
        end
        reg_wr = 1'b0;
        rd(3'd4, v); check("R9 tick reads set", v, 1);

        // R7 disabled timer stays quiet
        wr(3'd0, 8'h00); wr(3'd4, 8'h01);
        for (int k = 0; k < 3 * TICK; k++) begin
            @(negedge clk);
            check("R7 disabled no tick", int'(irq), 0);
        end

        // R8 restart from zero on re-enable
        wr(3'd0, 8'h01);
        repeat (TICK - 4) @(negedge clk);
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h01);
        for (int k = 1; k <= TICK; k++) begin
            @(negedge clk);
            check("R8 restart", int'(irq), int'(k >= TICK));
        end
        wr(3'd0, 8'h00); wr(3'd4, 8'h01);
        check("R9 tick cleared", int'(irq), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule